// File: doc/BRIEF.md
# Four-Port Interleaved Memory Bank Controller

This block is one memory module shared by four requesters: a processor on one port and I/O channels on the others. Each port decides for itself whether an incoming address falls in this module. The decision uses the port's enable, its configured base address, its interleave mode (two-way or four-way) and its module number within the interleave group. Interleaving chooses the module from the lowest word-address bits. The bits just above them give the internal word address. The bits above those must equal the base.

When several eligible ports request at once, the lowest-numbered one is served first. Requests that are not granted stay pending. A granted request runs one read or one write cycle. The port gets a single-clock acknowledge. A read returns data a fixed number of clocks later, on a per-port valid strobe. The module accepts no further request until the full cycle count has elapsed. Each stored word carries an odd parity bit, which is returned and checked on every read. The `WORD_AW` parameter sets the capacity. A value of 14 gives the full 16K-word module; the default is kept smaller for elaboration. `BUS_AW` selects an 18-bit or 22-bit port address.

Top module: `mport_mem_bank`

## Requirements
- R1: In two-way mode a port selects the module when address bit 0 equals bit 0 of its module number and address bits above `WORD_AW` (from bit `WORD_AW+1` up) equal the same bits of its base. The word address is then address bits `WORD_AW` down to 1.
- R2: In four-way mode a port selects the module when address bits 1:0 equal its 2-bit module number and address bits from `WORD_AW+2` up equal the same bits of its base. The word address is then address bits `WORD_AW+1` down to 2.
- R3: A port whose enable is low is never acknowledged, and a write it presents leaves memory unchanged.
- R4: Among eligible requesting ports, the lowest index is granted. At most one acknowledge is high in any cycle. Ports not granted keep their request and are granted in later cycles, in index order.
- R5: From idle, a request first seen at a clock edge is acknowledged for exactly one clock, in the cycle after that edge.
- R6: Two successive acknowledges are at least `CYCLE_CLKS` clocks apart. With requests pending, they are exactly `CYCLE_CLKS` apart.
- R7: For a read acknowledged in cycle n, the read-valid bit of that port alone is high for one clock in cycle n+`ACCESS_CLKS`-1. During that cycle the data output holds the word stored at the decoded address.
- R8: A write stores the data the port presents in its acknowledge cycle. The write occupies a full cycle before any other grant.
- R9: Each stored word carries odd parity, so the returned parity bit together with the 36 data bits holds an odd number of ones. An all-zero word returns parity 1. The parity-error flag is high only with a read-valid, and only when that odd-parity check fails.
- R10: A synchronous active-high reset returns the controller to idle. It clears acknowledges, read-valids and any cycle in progress, and it keeps memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en_i | input | NPORT | Per-port enable |
| cfg_four_i | input | NPORT | Per-port interleave: 1 four-way, 0 two-way |
| cfg_mod_i | input | NPORT x 2 | Per-port module number within the interleave group |
| cfg_base_i | input | NPORT x BUS_AW | Per-port base address; only the bits above the word field are used |
| req_i | input | NPORT | Request, held until acknowledged |
| req_wr_i | input | NPORT | 1 write, 0 read |
| req_addr_i | input | NPORT x BUS_AW | Request word address |
| req_wdata_i | input | NPORT x 36 | Write data |
| ack_o | output | NPORT | One-clock grant acknowledge |
| rd_valid_o | output | NPORT | One-clock read-data strobe |
| rd_data_o | output | 36 | Read data |
| rd_par_o | output | 1 | Stored parity of the read word |
| rd_perr_o | output | 1 | Parity mismatch on the current read |

## Verification
The checks assume that every requester holds its request, address, direction and data stable from the cycle it raises the request until it sees its acknowledge. They also assume that the configuration inputs change only while the module is idle. The stimulus meets both conditions. It runs in rounds: configurations and requests are applied together after an idle gap. Each port drops its request in the cycle its acknowledge is observed. All requests are withdrawn only after the last cycle of the round has finished. The parity checks assume a read targets a word that was written since power-up. The bench compares read data only for such words.

// File: rtl/mbk_pkg.sv
package mbk_pkg;

    localparam int WORD_BITS = 36;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

    // odd parity: returned bit makes the total count of ones odd
    function automatic logic odd_par(input logic [WORD_BITS-1:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/mbk_port_decode.sv
module mbk_port_decode #(
    parameter int BUS_AW  = 22,
    parameter int WORD_AW = 11
) (
    input  logic               en,
    input  logic               req,
    input  logic               four,
    input  logic [1:0]         modn,
    input  logic [BUS_AW-1:0]  base,
    input  logic [BUS_AW-1:0]  addr,
    output logic               hit,
    output logic [WORD_AW-1:0] word
);
    localparam int TOP2 = WORD_AW + 1;
    localparam int TOP4 = WORD_AW + 2;

    logic up2_ok, up4_ok, lo2_ok, lo4_ok, sel;

    always_comb begin
        up2_ok = (addr[BUS_AW-1:TOP2] == base[BUS_AW-1:TOP2]);
        up4_ok = (addr[BUS_AW-1:TOP4] == base[BUS_AW-1:TOP4]);
        lo2_ok = (addr[0] == modn[0]);
        lo4_ok = (addr[1:0] == modn);
        sel    = four ? (up4_ok & lo4_ok) : (up2_ok & lo2_ok);
        hit    = en & req & sel;
        word   = four ? addr[TOP4-1:2] : addr[TOP2-1:1];
    end

endmodule

// File: rtl/mbk_arbiter.sv
module mbk_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/mbk_store.sv
module mbk_store #(
    parameter int DW = 36,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rpar,
    output logic          rbad
);
    localparam int DEPTH = 1 << AW;

    logic [DW:0] mem [DEPTH];
    logic [DW:0] rword_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {mbk_pkg::odd_par(wdata), wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rword_q <= mem[raddr];
        end
    end

    always_comb begin
        rdata = rword_q[DW-1:0];
        rpar  = rword_q[DW];
        rbad  = ~(^rword_q);
    end

endmodule

// File: rtl/mport_mem_bank.sv
module mport_mem_bank #(
    parameter int NPORT       = 4,
    parameter int BUS_AW      = 22,
    parameter int WORD_AW     = 11,
    parameter int ACCESS_CLKS = 6,
    parameter int CYCLE_CLKS  = 10
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [NPORT-1:0]                          port_en_i,
    input  logic [NPORT-1:0]                          cfg_four_i,
    input  logic [NPORT-1:0][1:0]                     cfg_mod_i,
    input  logic [NPORT-1:0][BUS_AW-1:0]              cfg_base_i,
    input  logic [NPORT-1:0]                          req_i,
    input  logic [NPORT-1:0]                          req_wr_i,
    input  logic [NPORT-1:0][BUS_AW-1:0]              req_addr_i,
    input  logic [NPORT-1:0][mbk_pkg::WORD_BITS-1:0]  req_wdata_i,
    output logic [NPORT-1:0]                          ack_o,
    output logic [NPORT-1:0]                          rd_valid_o,
    output logic [mbk_pkg::WORD_BITS-1:0]             rd_data_o,
    output logic                                      rd_par_o,
    output logic                                      rd_perr_o
);
    import mbk_pkg::*;

    localparam int DW     = WORD_BITS;
    localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);
    localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLE_CLKS);
    localparam logic [CNT_W-1:0] CNT_RD   = CNT_W'(ACCESS_CLKS - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [PIDX_W-1:0]  port;
        logic               wr;
        logic [WORD_AW-1:0] addr;
        logic [NPORT-1:0]   ack;
        logic [NPORT-1:0]   rdv;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{phase: PH_IDLE, default: '0};

    logic [NPORT-1:0]              elig;
    logic [NPORT-1:0][WORD_AW-1:0] word;
    logic [NPORT-1:0]              gnt;
    logic [PIDX_W-1:0]             gidx;
    logic                          gany;

    genvar gp;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_dec
            mbk_port_decode #(
                .BUS_AW (BUS_AW),
                .WORD_AW(WORD_AW)
            ) u_dec (
                .en  (port_en_i[gp]),
                .req (req_i[gp]),
                .four(cfg_four_i[gp]),
                .modn(cfg_mod_i[gp]),
                .base(cfg_base_i[gp]),
                .addr(req_addr_i[gp]),
                .hit (elig[gp]),
                .word(word[gp])
            );
        end
    endgenerate

    mbk_arbiter #(
        .N (NPORT),
        .IW(PIDX_W)
    ) u_arb (
        .req(elig),
        .gnt(gnt),
        .idx(gidx),
        .any(gany)
    );

    ctl_t ctl_q, ctl_d;
    logic take, rd_en, mem_we, mem_bad;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = '0;
        ctl_d.rdv = '0;
        take      = 1'b0;
        rd_en     = 1'b0;

        // a new grant may start in idle or in the last cycle of the current one
        if ((ctl_q.phase == PH_IDLE || ctl_q.cnt == CNT_LAST) && gany) begin
            take        = 1'b1;
            ctl_d.phase = PH_BUSY;
            ctl_d.cnt   = CNT_ONE;
            ctl_d.port  = gidx;
            ctl_d.wr    = req_wr_i[gidx];
            ctl_d.addr  = word[gidx];
            ctl_d.ack   = gnt;
        end else if (ctl_q.phase == PH_BUSY) begin
            if (ctl_q.cnt == CNT_LAST) begin
                ctl_d.phase = PH_IDLE;
                ctl_d.cnt   = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_ONE;
            end
        end

        if (ctl_q.phase == PH_BUSY && !ctl_q.wr && ctl_q.cnt == CNT_RD) begin
            rd_en     = 1'b1;
            ctl_d.rdv = NPORT'(1) << ctl_q.port;
        end

        mem_we = take & req_wr_i[gidx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mbk_store #(
        .DW(DW),
        .AW(WORD_AW)
    ) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(word[gidx]),
        .wdata(req_wdata_i[gidx]),
        .re   (rd_en),
        .raddr(ctl_q.addr),
        .rdata(rd_data_o),
        .rpar (rd_par_o),
        .rbad (mem_bad)
    );

    always_comb begin
        ack_o      = ctl_q.ack;
        rd_valid_o = ctl_q.rdv;
        rd_perr_o  = mem_bad & (|ctl_q.rdv);
    end

endmodule

// File: rtl/mport_mem_bank_chk.sv
module mport_mem_bank_chk #(
    parameter int NPORT      = 4,
    parameter int CYCLE_CLKS = 10,
    parameter int DW         = 36
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] port_en_i,
    input logic [NPORT-1:0] req_i,
    input logic [NPORT-1:0] ack_o,
    input logic [NPORT-1:0] rd_valid_o,
    input logic [DW-1:0]    rd_data_o,
    input logic             rd_par_o,
    input logic             rd_perr_o
);
    logic [31:0] since_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (|ack_o) begin
            since_q <= 32'd1;
            seen_q  <= 1'b1;
        end else if (since_q != 32'hFFFF_FFFF) begin
            since_q <= since_q + 32'd1;
        end
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|ack_o) |=> !(|ack_o)); // R5
    AST_ACK_FROM_ENABLED_REQ: assert property (@(posedge clk) disable iff (rst)
        (|ack_o) |-> (|(ack_o & $past(req_i & port_en_i)))); // R3
    AST_GRANT_SPACING: assert property (@(posedge clk) disable iff (rst)
        ((|ack_o) && seen_q) |-> (since_q >= 32'(CYCLE_CLKS))); // R6
    AST_RDV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_valid_o)); // R7
    AST_PERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        rd_perr_o |-> (|rd_valid_o)); // R9
    AST_READ_ODD: assert property (@(posedge clk) disable iff (rst)
        ((|rd_valid_o) && !rd_perr_o) |-> (^{rd_data_o, rd_par_o})); // R9

endmodule

bind mport_mem_bank mport_mem_bank_chk #(
    .NPORT     (NPORT),
    .CYCLE_CLKS(CYCLE_CLKS),
    .DW        (mbk_pkg::WORD_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_en_i (port_en_i),
    .req_i     (req_i),
    .ack_o     (ack_o),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .rd_par_o  (rd_par_o),
    .rd_perr_o (rd_perr_o)
);

// File: tb/mport_mem_bank_test.sv
module mport_mem_bank_test;
    localparam int NP  = 4;
    localparam int BAW = 22;
    localparam int WAW = 11;
    localparam int ACC = 6;
    localparam int CYC = 10;
    localparam int DW  = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NP-1:0]          en, four, req, wr;
    logic [NP-1:0][1:0]     modn;
    logic [NP-1:0][BAW-1:0] base, addr;
    logic [NP-1:0][DW-1:0]  wd;
    logic [NP-1:0]          ack, rdv;
    logic [DW-1:0]          rdata;
    logic                   rpar, rperr;

    mport_mem_bank #(
        .NPORT(NP), .BUS_AW(BAW), .WORD_AW(WAW),
        .ACCESS_CLKS(ACC), .CYCLE_CLKS(CYC)
    ) uut (
        .clk(clk), .rst(rst),
        .port_en_i(en), .cfg_four_i(four), .cfg_mod_i(modn), .cfg_base_i(base),
        .req_i(req), .req_wr_i(wr), .req_addr_i(addr), .req_wdata_i(wd),
        .ack_o(ack), .rd_valid_o(rdv), .rd_data_o(rdata),
        .rd_par_o(rpar), .rd_perr_o(rperr)
    );

    int nchk  = 0;
    int nfail = 0;
    logic [DW-1:0] model [int];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // expected selection and word index, from R1 and R2
    function automatic bit exp_hit(input int p, output int w);
        int sh, lm;
        longint a, b;
        sh = four[p] ? 2 : 1;
        lm = four[p] ? 3 : 1;
        a  = longint'(addr[p]);
        b  = longint'(base[p]);
        w  = int'((a >> sh) & ((1 << WAW) - 1));
        return en[p] && ((a & lm) == (modn[p] & lm)) &&
               ((a >> (WAW + sh)) == (b >> (WAW + sh)));
    endfunction

    function automatic logic [BAW-1:0] mk_addr(input int p, input int w);
        int sh, lm;
        longint a;
        sh = four[p] ? 2 : 1;
        lm = four[p] ? 3 : 1;
        a  = (longint'(base[p]) & ~((longint'(1) << (WAW + sh)) - 1)) |
             (longint'(w) << sh) | longint'(modn[p] & lm);
        return a[BAW-1:0];
    endfunction

    task automatic set_port(input int p, input bit e, input bit f, input int m,
                            input int b, input bit w, input int word,
                            input logic [DW-1:0] d, input bit r);
        en[p] = e; four[p] = f; modn[p] = 2'(m); base[p] = BAW'(b);
        wr[p] = w; wd[p] = d; req[p] = r;
        addr[p] = mk_addr(p, word);
    endtask

    // caller is just after a falling edge; requests are applied now
    task automatic run_round();
        bit pend[NP];
        int wrd[NP];
        int npend, last_k, rd_at, rd_port;
        logic [DW-1:0] rd_exp;
        bit rd_known;
        npend = 0;
        rd_at = -1; rd_port = 0; rd_exp = '0; rd_known = 0;
        for (int p = 0; p < NP; p++) begin
            pend[p] = req[p] && exp_hit(p, wrd[p]);
            if (pend[p]) npend++;
        end
        last_k = 1 + npend * CYC + CYC;
        for (int k = 1; k <= last_k; k++) begin
            logic [NP-1:0] eack, erdv;
            @(negedge clk);
            eack = '0;
            if (((k - 1) % CYC) == 0 && ((k - 1) / CYC) < npend) begin
                for (int p = NP - 1; p >= 0; p--) begin
                    if (pend[p]) begin
                        eack    = '0;
                        eack[p] = 1'b1;
                    end
                end
            end
            // R3 R4 R5 R6: exact acknowledge vector every cycle
            chk(ack === eack, "R4", "ack vector (R3 R5 R6)", 64'(ack), 64'(eack));
            for (int p = 0; p < NP; p++) begin
                if (eack[p]) begin
                    pend[p] = 0;
                    req[p]  = 1'b0;
                    if (wr[p]) begin
                        model[wrd[p]] = wd[p];  // R8
                    end else begin
                        rd_at    = k + ACC - 1;
                        rd_port  = p;
                        rd_known = model.exists(wrd[p]);
                        rd_exp   = rd_known ? model[wrd[p]] : '0;
                    end
                end
            end
            erdv = (k == rd_at) ? (NP'(1) << rd_port) : '0;
            chk(rdv === erdv, "R7", "read valid vector", 64'(rdv), 64'(erdv));
            if (k == rd_at && rd_known) begin
                chk(rdata === rd_exp, "R7", "read data (R1 R2 R8)", 64'(rdata), 64'(rd_exp));
                chk((^{rdata, rpar}) === 1'b1, "R9", "odd parity", 64'({rdata, rpar}), 64'(1));
                chk(rperr === 1'b0, "R9", "parity error flag", 64'(rperr), 64'(0));
            end
        end
        req = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R5 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        en = '0; four = '0; req = '0; wr = '0; modn = '0;
        base = '0; addr = '0; wd = '0;
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            // R10: outputs idle during reset
            chk(ack === '0 && rdv === '0 && rperr === 1'b0, "R10", "outputs in reset",
                64'({ack, rdv, rperr}), 64'(0));
        end
        rst = 1'b0;
        @(negedge clk);

        // R9: all-zero word stores parity 1 (two-way, module 1)
        set_port(1, 1, 0, 1, 'h15000, 1, 5, '0, 1);
        run_round();
        set_port(1, 1, 0, 1, 'h15000, 0, 5, '0, 1);
        run_round();
        set_port(1, 1, 0, 1, 'h15000, 0, 5, '0, 1);
        fork
            run_round();
            begin
                repeat (ACC) @(negedge clk);
                chk(rpar === 1'b1 && rdv[1] === 1'b1, "R9", "zero word parity",
                    64'({rdv[1], rpar}), 64'(3));
            end
        join

        // R4 R6: all four ports eligible, four-way, distinct words, writes
        for (int p = 0; p < NP; p++)
            set_port(p, 1, 1, 2, 'h2C000, 1, 20 + p, {4'(p), 32'hA5A5_0000 + 32'(p)}, 1);
        run_round();
        // read them back in one round, priority order
        for (int p = 0; p < NP; p++)
            set_port(p, 1, 1, 2, 'h2C000, 0, 23 - p, '0, 1);
        run_round();

        // R3: disabled port writes over word 20, port 2 then reads it
        set_port(0, 0, 1, 2, 'h2C000, 1, 20, 36'hF_FFFF_FFFF, 1);
        set_port(2, 1, 1, 2, 'h2C000, 0, 20, '0, 1);
        run_round();
        set_port(2, 1, 1, 2, 'h2C000, 0, 20, '0, 1);
        run_round();

        // R1 R2: wrong module number and wrong base are not selected
        set_port(0, 1, 0, 0, 'h2C000, 1, 20, 36'h1, 1);
        addr[0][0] = 1'b1;
        set_port(3, 1, 1, 1, 'h2C000, 1, 21, 36'h2, 1);
        addr[3][BAW-1] = ~addr[3][BAW-1];
        run_round();

        // R10: reset during a read cycle, then data survives
        set_port(1, 1, 0, 1, 'h15000, 0, 5, '0, 1);
        @(negedge clk);
        chk(ack === 4'b0010, "R10", "ack before reset", 64'(ack), 64'(2));
        req = '0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < CYC + 2; k++) begin
            @(negedge clk);
            chk(ack === '0 && rdv === '0, "R10", "no activity after reset",
                64'({ack, rdv}), 64'(0));
        end
        set_port(2, 1, 1, 2, 'h2C000, 0, 21, '0, 1);
        run_round();  // R10: word written before reset still read back

        // random rounds
        for (int r = 0; r < 200; r++) begin
            for (int p = 0; p < NP; p++) begin
                set_port(p, ($urandom % 5) != 0, $urandom % 2, $urandom % 4,
                         int'($urandom), $urandom % 2, $urandom % 16,
                         {4'($urandom), 32'($urandom)}, ($urandom % 4) != 0);
                if (($urandom % 4) == 0) addr[p] = BAW'($urandom);
            end
            run_round();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule